// File: doc/BRIEF.md
# Shutter-Gated Hit and Charge Tally

This block is the counting stage of one pixel running in event-counting mode. While a shutter window is open it keeps two tallies side by side: how many times the discriminator crossed threshold, and how many system clock cycles in total the discriminator spent above threshold. The second tally is a coarse measure of the charge collected during the window.

The tallies are frozen and flagged as valid for readout in one of two ways. In frame mode the flag rises when the shutter closes. In data-driven mode the flag rises on a readout request while the shutter may still be open. While the flag is high, counting pauses. An acknowledge clears both tallies and the flag. Opening a new shutter also clears both tallies and the flag.

A mask input silences the pixel completely. Both tallies stop at their largest values instead of wrapping.

Top module: `hit_tally_pixel`

## Requirements
- R1: `hit_cnt` (10 bits) increments by one on each clock edge where `disc_in` is high and was low at the previous edge, provided counting is enabled.
- R2: `tot_sum` (14 bits) increments by one on each clock edge where `disc_in` is high, provided counting is enabled.
- R3: Three pulses that spend a total of five cycles above threshold read back `hit_cnt` = 3 and `tot_sum` = 5.
- R4: When `mode_dd` = 0, `cnt_valid` rises at the first clock edge that samples `shutter` low after it was sampled high.
- R5: When `mode_dd` = 1, `rd_req` sampled high while `cnt_valid` is low sets `cnt_valid` at that edge. While `cnt_valid` is high, neither tally changes.
- R6: `rd_ack` sampled high while `cnt_valid` is high clears both tallies and `cnt_valid` at that edge.
- R7: Both tallies saturate: `hit_cnt` holds at 1023 and `tot_sum` holds at 16383.
- R8: While `mask` is high, neither tally increments.
- R9: The edge that first samples `shutter` high clears both tallies and `cnt_valid`. Activity sampled at that same edge is counted from zero.
- R10: After reset, both tallies are 0 and `cnt_valid` is 0.
- R11: While `shutter` is low, neither tally increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | 1 | Discriminator output, synchronous to clk |
| shutter | input | 1 | High while the acquisition window is open |
| mask | input | 1 | High disables all counting for this pixel |
| mode_dd | input | 1 | 1 selects data-driven readout, 0 selects frame readout |
| rd_req | input | 1 | Data-driven readout request |
| rd_ack | input | 1 | Readout acknowledge; clears the tallies |
| hit_cnt | output | 10 | Number of threshold crossings |
| tot_sum | output | 14 | Cycles spent above threshold |
| cnt_valid | output | 1 | Tallies are frozen and ready to read |

## Verification
The bench sweeps pulse count against pulse width and compares both tallies with their products. A design that counted levels instead of edges, or that dropped the first cycle of each pulse, would miss those products.

It holds the discriminator high for longer than the charge range and sends more pulses than the hit range. A wrapping counter would then read back a small value.

It also checks the following cases:
- hits while masked or while the shutter is closed;
- hits during a pending data-driven readout;
- counting that restarts after an acknowledge;
- a new shutter that opens without an acknowledge.

A design with faulty gating or clearing would keep stale counts or gain extra counts in these cases.

// File: rtl/hit_tally_pkg.sv
// Shared widths for the pixel tally block.
package hit_tally_pkg;
    localparam int HIT_W = 10;
    localparam int TOT_W = 14;
endpackage

// File: rtl/hit_edge_sense.sv
// Detects the rising edge of a synchronous discriminator signal.
// Assumes disc_in is already synchronous to clk.
module hit_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic disc_in,
    output logic rise
);
    logic disc_q;

    // Keeps the previous sample of the discriminator.
    always_ff @(posedge clk) begin
        if (!rst_n) disc_q <= 1'b0;
        else        disc_q <= disc_in;
    end

    assign rise = disc_in & ~disc_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R1
endmodule

// File: rtl/sat_tally.sv
// Saturating up-counter with a synchronous clear.
// When clr and inc are both high, the counter restarts from zero and counts once.
module sat_tally #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    logic [W-1:0] base;

    assign base = clr ? '0 : cnt;

    // Adds one unless the counter has reached its ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (inc && base != MAXV) cnt <= base + 1'b1;
        else                          cnt <= base;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV); // R7
    AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt)); // R7
endmodule

// File: rtl/tally_readout_ctrl.sv
// Tracks the shutter and owns the valid flag for both readout modes.
// Frame mode raises valid on shutter close; data-driven mode raises it on request.
module tally_readout_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic shutter,
    input  logic mode_dd,
    input  logic rd_req,
    input  logic rd_ack,
    output logic open_edge,
    output logic clr_cnt,
    output logic valid
);
    logic shutter_q;
    logic close_edge;
    logic start_rd;

    assign open_edge  = shutter & ~shutter_q;
    assign close_edge = ~shutter & shutter_q;
    assign start_rd   = mode_dd ? rd_req : close_edge;
    assign clr_cnt    = open_edge | (valid & rd_ack);

    // Remembers the shutter level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) shutter_q <= 1'b0;
        else        shutter_q <= shutter;
    end

    // Sets valid on readout start and drops it on acknowledge or a new frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 valid <= 1'b0;
        else if (open_edge)         valid <= 1'b0;
        else if (valid && rd_ack)   valid <= 1'b0;
        else if (!valid && start_rd) valid <= 1'b1;
    end

    AST_FRAME_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dd && !valid && shutter_q && !shutter) |=> valid); // R4
    AST_DD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dd && !valid && rd_req && !open_edge) |=> valid); // R5
    AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        open_edge |=> !valid); // R9
endmodule

// File: rtl/hit_tally_pixel.sv
// Per-pixel event and charge tally, gated by the shutter and the mask.
// Assumes disc_in, shutter and the readout controls are synchronous to clk.
module hit_tally_pixel
    import hit_tally_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disc_in,
    input  logic             shutter,
    input  logic             mask,
    input  logic             mode_dd,
    input  logic             rd_req,
    input  logic             rd_ack,
    output logic [HIT_W-1:0] hit_cnt,
    output logic [TOT_W-1:0] tot_sum,
    output logic             cnt_valid
);
    logic rise;
    logic open_edge;
    logic clr_cnt;
    logic count_en;

    hit_edge_sense u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .disc_in (disc_in),
        .rise    (rise)
    );

    tally_readout_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .shutter   (shutter),
        .mode_dd   (mode_dd),
        .rd_req    (rd_req),
        .rd_ack    (rd_ack),
        .open_edge (open_edge),
        .clr_cnt   (clr_cnt),
        .valid     (cnt_valid)
    );

    // Counting is enabled inside an open, unmasked window with no pending readout.
    assign count_en = shutter & ~mask & (~cnt_valid | open_edge);

    sat_tally #(.W(HIT_W)) u_hits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .inc   (count_en & rise),
        .cnt   (hit_cnt)
    );

    sat_tally #(.W(TOT_W)) u_tot (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .inc   (count_en & disc_in),
        .cnt   (tot_sum)
    );

    AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !clr_cnt) |=> ($stable(hit_cnt) && $stable(tot_sum))); // R8
    AST_CLOSED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutter && !clr_cnt) |=> ($stable(hit_cnt) && $stable(tot_sum))); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && rd_ack) |=> (!cnt_valid && hit_cnt == '0 && tot_sum == '0)); // R6
    AST_HOLD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !clr_cnt) |=> ($stable(hit_cnt) && $stable(tot_sum))); // R5
    AST_HITS_LE_TOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tot_sum < 14'd1000) |-> ({4'd0, hit_cnt} <= tot_sum)); // R1
endmodule

// File: tb/tb_hit_tally_pixel.sv
module tb_hit_tally_pixel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disc_in = 1'b0;
    logic shutter = 1'b0;
    logic mask = 1'b0;
    logic mode_dd = 1'b0;
    logic rd_req = 1'b0;
    logic rd_ack = 1'b0;
    logic [9:0]  hit_cnt;
    logic [13:0] tot_sum;
    logic        cnt_valid;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hit_tally_pixel dut (
        .clk(clk), .rst_n(rst_n), .disc_in(disc_in), .shutter(shutter),
        .mask(mask), .mode_dd(mode_dd), .rd_req(rd_req), .rd_ack(rd_ack),
        .hit_cnt(hit_cnt), .tot_sum(tot_sum), .cnt_valid(cnt_valid)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int eh, input int et, input bit ev);
        n_tests++;
        if (hit_cnt != eh || tot_sum != et || cnt_valid != ev) begin
            n_fail++;
            $display("FAIL %s: got hit=%0d tot=%0d valid=%0d, expected hit=%0d tot=%0d valid=%0d",
                     req, hit_cnt, tot_sum, cnt_valid, eh, et, ev);
        end
    endtask

    task automatic pulse(input int len, input int gap);
        disc_in = 1'b1; tick(len);
        disc_in = 1'b0; tick(gap);
    endtask

    task automatic open_shutter();
        shutter = 1'b1; tick(2);
    endtask

    task automatic close_shutter();
        shutter = 1'b0; tick(2);
    endtask

    task automatic ack();
        rd_ack = 1'b1; tick(1);
        rd_ack = 1'b0; tick(1);
    endtask

    initial begin
        tick(3);
        check("R10 reset", 0, 0, 0);
        rst_n = 1'b1; tick(1);

        // R3 worked example, frame mode
        open_shutter();
        pulse(1, 2); pulse(2, 2); pulse(2, 2);
        check("R3 before close", 3, 5, 0);
        close_shutter();
        check("R3 R4 frame readout", 3, 5, 1);
        ack();
        check("R6 ack clears", 0, 0, 0);

        // R1 R2 sweep: n pulses of width L
        for (int n = 1; n <= 6; n++) begin
            for (int l = 1; l <= 4; l++) begin
                open_shutter();
                for (int k = 0; k < n; k++) pulse(l, 1 + (k % 3));
                close_shutter();
                check("R1 R2 sweep", n, n * l, 1);
                ack();
            end
        end

        // R8 masked pixel
        mask = 1'b1;
        open_shutter();
        pulse(3, 2); pulse(1, 2);
        close_shutter();
        check("R8 mask", 0, 0, 1);
        ack();
        mask = 1'b0;

        // R11 shutter closed
        pulse(4, 2); pulse(2, 2);
        check("R11 closed shutter", 0, 0, 0);

        // R7 charge saturation
        open_shutter();
        pulse(16400, 2);
        close_shutter();
        check("R7 tot saturates", 1, 16383, 1);
        ack();

        // R7 hit saturation
        open_shutter();
        for (int k = 0; k < 1100; k++) pulse(1, 1);
        close_shutter();
        check("R7 hits saturate", 1023, 1100, 1);
        ack();

        // R5 data-driven readout during open shutter
        mode_dd = 1'b1;
        open_shutter();
        pulse(2, 2); pulse(3, 2);
        rd_req = 1'b1; tick(1); rd_req = 1'b0;
        check("R5 dd valid", 2, 5, 1);
        pulse(2, 2);
        check("R5 frozen while valid", 2, 5, 1);
        ack();
        check("R6 dd ack clears", 0, 0, 0);
        pulse(4, 2);
        check("R5 counting resumes", 1, 4, 0);
        close_shutter();
        check("R5 dd no valid on close", 1, 4, 0);
        mode_dd = 1'b0;

        // R9 new shutter clears without ack
        open_shutter();
        pulse(2, 2);
        close_shutter();
        check("R9 frame ready", 1, 2, 1);
        shutter = 1'b1; tick(1);
        check("R9 reopen clears", 0, 0, 0);
        tick(1);

        // R9 activity at the opening edge counts from zero
        shutter = 1'b0; tick(2); ack();
        shutter = 1'b1; disc_in = 1'b1; tick(2);
        disc_in = 1'b0; tick(2);
        check("R9 open-edge hit", 1, 2, 0);
        close_shutter(); ack();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule